// File: doc/BRIEF.md
# Packet framing serializer

This block turns a single pre-coded 10-bit symbol into a framed serial bit stream. The symbol enters through a valid/ready handshake and is held in an output shift register. A transmit request stays pending until the line is eligible to start a frame. Every change in the serial output happens only on core-clock cycles where a once-per-bit strobe is high, so the bit rate is set outside the block.

While no frame is in flight, the line carries an alternating idle pattern. A frame starts only when two things are true: at least ten idle bits have gone out since the last frame (or since reset), and the most recent idle bit was a one. The frame is then four extra one bits as a start marker, followed by the ten symbol bits, most significant bit first. After the last symbol bit the block goes back to idle and drops its busy flag.

A two-bit status word gives software the busy flag and a transmit-enable bit. Only the enable bit can be written, and a dedicated output mirrors it. Back-pressure rule: `sym_ready` is high exactly when no frame is pending or in flight. A symbol is taken on a clock edge where `sym_valid` and `sym_ready` are both high. A symbol offered while `sym_ready` is low is not taken and leaves the pending frame untouched. `sym_valid` may be withdrawn at any time.

Top module: `frame_serializer`

## Requirements
- R1: `tx_bit` and all sequencer state change only on rising clock edges where `bit_en` is high.
- R2: A handshake (`sym_valid` and `sym_ready` high at an edge) stores `sym_data` and sets busy (status bit 1) at that edge. `sym_ready` equals the inverse of busy.
- R3: In idle, each bit strobe sends the complement of the previous bit. After reset the previous bit is 0, so the first idle bit is 1.
- R4: A pending frame starts on a bit strobe only if at least 10 idle bits have been sent since reset or since the previous frame ended, and the bit sent just before was 1. Otherwise idle continues.
- R5: A frame begins with exactly four consecutive marker bits of value 1.
- R6: The ten symbol bits follow the marker, bit 9 first and bit 0 last. Busy clears on the edge that sends bit 0, and the next strobe sends an idle bit.
- R7: A symbol offered while busy is not accepted (`sym_ready` low) and does not change the bits of the frame being sent.
- R8: Status bit 1 is busy and status bit 0 is transmit enable. A `ctl_wr` write stores `ctl_wdata[0]` into enable and ignores `ctl_wdata[1]`. `tx_enable` equals the enable bit.
- R9: After reset, `tx_bit`, busy and enable are 0, `sym_ready` is 1, and the sequencer is idle with an idle count of zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | Once-per-bit advance strobe |
| sym_valid | input | 1 | Symbol offer |
| sym_ready | output | 1 | Block can accept a symbol |
| sym_data | input | 10 | Coded symbol |
| ctl_wr | input | 1 | Status register write strobe |
| ctl_wdata | input | 2 | Status write data (only bit 0 used) |
| status | output | 2 | {busy, enable} |
| tx_bit | output | 1 | Serial line output |
| tx_enable | output | 1 | Transmit enable |

## Verification
The bench sends frames back to back, so the ten-bit idle minimum is tested right after a frame ends. A design that counted from the wrong point would start the marker too early. The bench also offers symbols at moments when the last idle bit was a zero; a design that ignored the polarity rule would start a frame one bit early and misalign the marker. It holds a second symbol on the input throughout a frame. A design that accepted it would corrupt the bits in flight or start an extra frame. Status writes with only the busy bit set check that busy cannot be forced, and all-ones and all-zero symbols show a marker that is too short or too long, or data sent in the wrong bit order.

// File: rtl/fs_pkg.sv
package fs_pkg;
  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_MARK = 2'd1,
    S_DATA = 2'd2
  } seq_state_t;

  localparam int STAT_W = 2;
  localparam int STAT_BUSY = 1;
  localparam int STAT_ENB = 0;
endpackage

// File: rtl/fs_shifter.sv
module fs_shifter #(
  parameter int SYM_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             shift,
  input  logic [SYM_W-1:0] din,
  output logic             msb
);
  logic [SYM_W-1:0] sr_q;

  always_ff @(posedge clk) begin
    if (!rst_n)     sr_q <= '0;
    else if (load)  sr_q <= din;
    else if (shift) sr_q <= {sr_q[SYM_W-2:0], 1'b0};
  end

  assign msb = sr_q[SYM_W-1];

  // R7: held contents stay put unless loaded or shifted
  a_r7_hold_contents: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !shift) |=> $stable(sr_q));
endmodule

// File: rtl/fs_sequencer.sv
module fs_sequencer
  import fs_pkg::*;
#(
  parameter int SYM_W    = 10,
  parameter int MARK_LEN = 4,
  parameter int IDLE_MIN = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_en,
  input  logic busy_i,
  input  logic msb_i,
  output logic shift_o,
  output logic done_o,
  output logic tx_o
);
  localparam int IC_W = $clog2(IDLE_MIN + 1);
  localparam int MC_W = $clog2(MARK_LEN + 1);
  localparam int DC_W = $clog2(SYM_W + 1);
  localparam logic [IC_W-1:0] IDLE_LIM = IC_W'(IDLE_MIN);
  localparam logic [MC_W-1:0] MARK_LIM = MC_W'(MARK_LEN);
  localparam logic [DC_W-1:0] DATA_LAST = DC_W'(SYM_W - 1);

  seq_state_t      state_q, state_d;
  logic [IC_W-1:0] idle_cnt, idle_cnt_d;
  logic [MC_W-1:0] mark_cnt, mark_cnt_d;
  logic [DC_W-1:0] data_cnt, data_cnt_d;
  logic            tx_q, tx_d;
  logic            start_ok;

  assign start_ok = busy_i && (idle_cnt >= IDLE_LIM) && tx_q;

  always_comb begin
    state_d    = state_q;
    idle_cnt_d = idle_cnt;
    mark_cnt_d = mark_cnt;
    data_cnt_d = data_cnt;
    tx_d       = tx_q;
    shift_o    = 1'b0;
    done_o     = 1'b0;
    if (bit_en) begin
      unique case (state_q)
        S_IDLE: begin
          if (start_ok) begin
            state_d    = S_MARK;
            tx_d       = 1'b1;
            mark_cnt_d = MC_W'(1);
          end else begin
            tx_d = ~tx_q;
            if (idle_cnt < IDLE_LIM) idle_cnt_d = idle_cnt + 1'b1;
          end
        end
        S_MARK: begin
          if (mark_cnt == MARK_LIM) begin
            state_d    = S_DATA;
            tx_d       = msb_i;
            shift_o    = 1'b1;
            data_cnt_d = DC_W'(1);
          end else begin
            tx_d       = 1'b1;
            mark_cnt_d = mark_cnt + 1'b1;
          end
        end
        S_DATA: begin
          tx_d    = msb_i;
          shift_o = 1'b1;
          if (data_cnt == DATA_LAST) begin
            state_d    = S_IDLE;
            idle_cnt_d = '0;
            done_o     = 1'b1;
          end else begin
            data_cnt_d = data_cnt + 1'b1;
          end
        end
        default: state_d = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= S_IDLE;
      idle_cnt <= '0;
      mark_cnt <= '0;
      data_cnt <= '0;
      tx_q     <= 1'b0;
    end else begin
      state_q  <= state_d;
      idle_cnt <= idle_cnt_d;
      mark_cnt <= mark_cnt_d;
      data_cnt <= data_cnt_d;
      tx_q     <= tx_d;
    end
  end

  assign tx_o = tx_q;

  // R1: nothing moves between bit strobes
  a_r1_no_move: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> ($stable(tx_q) && $stable(state_q)));
  // R4: a frame is entered only from an eligible idle line
  a_r4_start_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_MARK && $past(state_q) == S_IDLE) |->
      ($past(tx_q) && ($past(idle_cnt) >= IDLE_LIM) && $past(busy_i)));
  // R5: line is high throughout the marker
  a_r5_mark_high: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_MARK) |-> tx_q);
  // R6: a frame in flight always has busy set
  a_r6_busy_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != S_IDLE) |-> busy_i);
endmodule

// File: rtl/fs_status.sv
module fs_status
  import fs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept_i,
  input  logic              done_i,
  input  logic              wr_i,
  input  logic [STAT_W-1:0] wdata_i,
  output logic              busy_o,
  output logic [STAT_W-1:0] status_o
);
  logic busy_q, enb_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      enb_q  <= 1'b0;
    end else begin
      if (accept_i)    busy_q <= 1'b1;
      else if (done_i) busy_q <= 1'b0;
      if (wr_i) enb_q <= wdata_i[STAT_ENB];
    end
  end

  always_comb begin
    status_o            = '0;
    status_o[STAT_BUSY] = busy_q;
    status_o[STAT_ENB]  = enb_q;
  end
  assign busy_o = busy_q;

  // R2: an accepted symbol raises busy
  a_r2_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
    accept_i |=> busy_q);
  // R8: register writes cannot move busy
  a_r8_busy_readonly: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && !accept_i && !done_i) |=> $stable(busy_q));
endmodule

// File: rtl/frame_serializer.sv
module frame_serializer
  import fs_pkg::*;
#(
  parameter int SYM_W    = 10,
  parameter int MARK_LEN = 4,
  parameter int IDLE_MIN = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_en,
  input  logic             sym_valid,
  output logic             sym_ready,
  input  logic [SYM_W-1:0] sym_data,
  input  logic             ctl_wr,
  input  logic [1:0]       ctl_wdata,
  output logic [1:0]       status,
  output logic             tx_bit,
  output logic             tx_enable
);
  logic busy, accept, shift, done, msb;

  assign sym_ready = !busy;
  assign accept    = sym_valid && sym_ready;

  fs_shifter #(.SYM_W(SYM_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(accept), .shift(shift),
    .din(sym_data), .msb(msb)
  );

  fs_sequencer #(.SYM_W(SYM_W), .MARK_LEN(MARK_LEN), .IDLE_MIN(IDLE_MIN)) u_seq (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .busy_i(busy), .msb_i(msb),
    .shift_o(shift), .done_o(done), .tx_o(tx_bit)
  );

  fs_status u_stat (
    .clk(clk), .rst_n(rst_n), .accept_i(accept), .done_i(done),
    .wr_i(ctl_wr), .wdata_i(ctl_wdata), .busy_o(busy), .status_o(status)
  );

  assign tx_enable = status[STAT_ENB];

  // R7: a blocked offer leaves busy high on the next edge
  a_r7_blocked_offer: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_valid && !sym_ready && !done) |=> !sym_ready);
endmodule

// File: tb/sim_frame_serializer.sv
module sim_frame_serializer;
  localparam int BIT_DIV = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bit_en = 1'b0;
  logic       sym_valid = 1'b0;
  logic       sym_ready;
  logic [9:0] sym_data = '0;
  logic       ctl_wr = 1'b0;
  logic [1:0] ctl_wdata = '0;
  logic [1:0] status;
  logic       tx_bit;
  logic       tx_enable;

  int checks = 0;
  int fails = 0;
  logic [9:0] sb_q[$];
  logic       exp_bits[$];
  logic       run_mon = 1'b0;
  int         div = 0;

  frame_serializer u0 (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .sym_valid(sym_valid),
    .sym_ready(sym_ready), .sym_data(sym_data), .ctl_wr(ctl_wr),
    .ctl_wdata(ctl_wdata), .status(status), .tx_bit(tx_bit),
    .tx_enable(tx_enable)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    div    <= (div == BIT_DIV - 1) ? 0 : div + 1;
    bit_en <= rst_n && (div == BIT_DIV - 2);
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Monitor: independent model of the line, scoreboard of symbols
  initial begin
    logic last = 1'b0;
    int   idle_run = 0;
    logic prev = 1'b0;
    logic exp;
    string tag;
    forever begin
      @(posedge clk);
      if (run_mon) begin
        if (bit_en) begin
          #1;
          if (exp_bits.size() > 0) begin
            exp = exp_bits.pop_front();
            tag = (exp_bits.size() >= 10) ? "R5 marker" : "R6 data";
            chk(tag, tx_bit, exp);
            if (exp_bits.size() == 0) begin
              idle_run = 0;
              chk("R6 busy cleared", status[1], 1'b0);
            end
          end else if (sb_q.size() > 0 && idle_run >= 10 && last) begin
            logic [9:0] s;
            s = sb_q.pop_front();
            for (int i = 0; i < 3; i++) exp_bits.push_back(1'b1);
            for (int i = 9; i >= 0; i--) exp_bits.push_back(s[i]);
            chk("R4 R5 frame start", tx_bit, 1'b1);
          end else begin
            exp = ~last;
            tag = (sb_q.size() > 0) ? "R4 wait idle" : "R3 idle";
            chk(tag, tx_bit, exp);
            idle_run++;
          end
          last = tx_bit;
          prev = tx_bit;
        end else begin
          #1;
          chk("R1 hold", tx_bit, prev);
        end
      end
    end
  end

  task automatic send_sym(input logic [9:0] d);
    @(negedge clk);
    while (!(sym_ready && !bit_en)) @(negedge clk);
    sym_valid = 1'b1;
    sym_data  = d;
    @(posedge clk);
    sb_q.push_back(d);
    @(negedge clk);
    sym_valid = 1'b0;
    chk("R2 busy set", status[1], 1'b1);
    chk("R2 ready low", sym_ready, 1'b0);
  endtask

  task automatic wait_idle();
    while (sb_q.size() > 0 || exp_bits.size() > 0 || status[1]) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R9 tx_bit", tx_bit, 1'b0);
    chk("R9 status", status, 2'b00);
    chk("R9 ready", sym_ready, 1'b1);
    chk("R9 enable", tx_enable, 1'b0);
    rst_n = 1'b1;
    run_mon = 1'b1;

    // R8 writes
    @(negedge clk); ctl_wr = 1'b1; ctl_wdata = 2'b10;
    @(negedge clk); ctl_wr = 1'b0;
    chk("R8 busy not writable", status, 2'b00);
    ctl_wr = 1'b1; ctl_wdata = 2'b01;
    @(negedge clk); ctl_wr = 1'b0;
    chk("R8 enable set", status, 2'b01);
    chk("R8 tx_enable mirror", tx_enable, 1'b1);

    // frames, including back to back
    send_sym(10'h3FF);
    send_sym(10'h000);
    send_sym(10'h2AA);
    wait_idle();

    // R7: offer a second symbol while busy
    send_sym(10'h155);
    @(negedge clk);
    sym_valid = 1'b1; sym_data = 10'h0F0;
    for (int i = 0; i < 20; i++) begin
      chk("R7 ready low while busy", sym_ready, 1'b0);
      @(negedge clk);
    end
    sym_valid = 1'b0;
    wait_idle();

    // offset timing so the offer lands on a different idle phase
    repeat (BIT_DIV * 7 + 1) @(negedge clk);
    send_sym(10'h201);
    wait_idle();
    ctl_wr = 1'b1; ctl_wdata = 2'b00;
    @(negedge clk); ctl_wr = 1'b0;
    chk("R8 enable cleared", status, 2'b00);
    repeat (BIT_DIV * 3) @(negedge clk);
    run_mon = 1'b0;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule